// File: doc/BRIEF.md
# Windowed Fixed-Frame Video Timing Generator

This block generates one output raster of fixed size on the pixel clock. By default the raster is 1920x1080 at 60 Hz, with 2200 clocks per line and 1125 lines per frame. It drives horizontal sync, vertical sync and data enable. The frame geometry never changes. Sources of different sizes are shown by placing a picture window inside the active area. The window has a start offset and a width and height, all set at run time.

A pixel is inside the window when it is in the active area and in the window rectangle. For each such pixel, the block raises a request strobe one clock ahead of that pixel's data enable. The strobe drives the read enable of a frame-buffer port with one cycle of read latency. The block passes the returned 24-bit colour word to the output. Every other pixel is driven as black: pixels in the active area but outside the window, and all blanking pixels.

The window settings are captured once per frame, when the counters stand at the first clock of the frame. A change made part-way through a frame therefore cannot tear the picture.

Top module: `vtg_frame_raster`

## Requirements
- R1: While reset is asserted, all outputs are low: both syncs, data enable, the request strobe and the colour word. Once reset is released, the raster starts at line 0, clock 0. That first position appears on the request strobe after the first clock edge and on the sync and enable outputs after the second.
- R2: Horizontal sync is high, active high, for the first H_SYNC clocks of every line. The line has H_SYNC + H_BP + H_ACT + H_FP clocks.
- R3: Vertical sync is high, active high, for the whole of the first V_SYNC lines of every frame. The frame has V_SYNC + V_BP + V_ACT + V_FP lines.
- R4: Data enable is high exactly on the active area. On each line that is clocks H_SYNC+H_BP up to H_SYNC+H_BP+H_ACT-1. On each frame it is those clocks on lines V_SYNC+V_BP up to V_SYNC+V_BP+V_ACT-1. Data enable is never high together with either sync.
- R5: The request strobe is high one clock before the data enable of each pixel inside the window. Active column x and row y are counted from 0 at the first active pixel. A pixel is inside the window when start_x <= x < start_x+width and start_y <= y < start_y+height.
- R6: The request strobe stays low for active pixels outside the window. A window that reaches past the active area is clipped to it.
- R7: On a pixel inside the window, the colour output equals the colour input. On every other clock it is zero.
- R8: The window inputs are sampled only on the clock where the counters stand at line 0, clock 0. Changes at any other time take effect from the next frame.
- R9: A window of zero width or zero height raises no request and shows a fully black active area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously and released synchronous to clk |
| i_start_x | input | 11 | Window first column, relative to the first active column |
| i_start_y | input | 11 | Window first row, relative to the first active line |
| i_width | input | 11 | Window width in pixels |
| i_height | input | 11 | Window height in lines |
| i_rgb | input | 24 | Colour word from the frame buffer, valid one clock after a request |
| o_hs | output | 1 | Horizontal sync, active high |
| o_vs | output | 1 | Vertical sync, active high |
| o_de | output | 1 | Data enable for the active area |
| o_rgb | output | 24 | Output colour; zero outside the window |
| o_req | output | 1 | Frame-buffer read request, one clock ahead of the pixel |

## Verification
Several properties are checked on every clock by the embedded assertions. Data enable never coincides with a sync. Every request is followed by data enable. The colour word is zero whenever data enable is low. A captured zero-sized window never produces an in-window flag. The exact positions of the sync and enable edges, the window rectangle and its clipping, and the one-clock request lead can only be shown by the bench. It compares every output on every clock against a position model. The same holds for the pixel order of the returned colour words and for the deferral of a mid-frame window change to the next frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Width of every window coordinate and size input.
  localparam int unsigned VTG_SIZE_W = 11;

  // Window settings captured once per frame.
  typedef struct packed {
    logic [VTG_SIZE_W-1:0] sx;
    logic [VTG_SIZE_W-1:0] sy;
    logic [VTG_SIZE_W-1:0] w;
    logic [VTG_SIZE_W-1:0] h;
  } vtg_win_t;

  // Per-pixel flags carried down the output pipeline.
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    logic win;
  } vtg_flags_t;

endpackage

// File: rtl/vtg_scan_counter.sv
module vtg_scan_counter #(
  parameter  int unsigned H_TOTAL = 2200,
  parameter  int unsigned V_TOTAL = 1125,
  parameter  int unsigned H_SYNC  = 44,
  parameter  int unsigned V_SYNC  = 5,
  localparam int unsigned HW      = $clog2(H_TOTAL),
  localparam int unsigned VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          frame_start,
  output logic          line_sync,
  output logic          frame_sync
);

  logic          h_last;
  logic          v_last;
  logic [HW-1:0] hcnt_nxt;
  logic [VW-1:0] vcnt_nxt;

  always_comb begin
    h_last   = (hcnt == HW'(H_TOTAL - 1));
    v_last   = (vcnt == VW'(V_TOTAL - 1));
    hcnt_nxt = h_last ? '0 : hcnt + HW'(1);
    vcnt_nxt = vcnt;
    if (h_last) begin
      vcnt_nxt = v_last ? '0 : vcnt + VW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= hcnt_nxt;
      vcnt <= vcnt_nxt;
    end
  end

  always_comb begin
    frame_start = (hcnt == '0) && (vcnt == '0);
    line_sync   = (hcnt < HW'(H_SYNC));
    frame_sync  = (vcnt < VW'(V_SYNC));
  end

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != HW'(H_TOTAL - 1)) |=> (vcnt == $past(vcnt)));

endmodule

// File: rtl/vtg_window_gate.sv
module vtg_window_gate
  import vtg_pkg::*;
#(
  parameter  int unsigned H_TOTAL   = 2200,
  parameter  int unsigned V_TOTAL   = 1125,
  parameter  int unsigned H_ACT_BEG = 192,
  parameter  int unsigned V_ACT_BEG = 41,
  parameter  int unsigned H_ACT     = 1920,
  parameter  int unsigned V_ACT     = 1080,
  localparam int unsigned HW        = $clog2(H_TOTAL),
  localparam int unsigned VW        = $clog2(V_TOTAL),
  localparam int unsigned CW        = VTG_SIZE_W + 2,
  localparam int unsigned H_ACT_END = H_ACT_BEG + H_ACT,
  localparam int unsigned V_ACT_END = V_ACT_BEG + V_ACT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [HW-1:0]         hcnt,
  input  logic [VW-1:0]         vcnt,
  input  logic                  frame_start,
  input  logic [VTG_SIZE_W-1:0] start_x,
  input  logic [VTG_SIZE_W-1:0] start_y,
  input  logic [VTG_SIZE_W-1:0] width,
  input  logic [VTG_SIZE_W-1:0] height,
  output logic                  in_active,
  output logic                  in_window
);

  vtg_win_t      win_q;
  vtg_win_t      win_nxt;
  logic [CW-1:0] col;
  logic [CW-1:0] row;
  logic [CW-1:0] col_end;
  logic [CW-1:0] row_end;
  logic          h_act;
  logic          v_act;
  logic          h_in;
  logic          v_in;

  // Window capture: load enable is the frame-start position only.
  always_comb begin
    win_nxt = win_q;
    if (frame_start) begin
      win_nxt.sx = start_x;
      win_nxt.sy = start_y;
      win_nxt.w  = width;
      win_nxt.h  = height;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else begin
      win_q <= win_nxt;
    end
  end

  // Position compare against the active area and the window rectangle.
  always_comb begin
    h_act     = (hcnt >= HW'(H_ACT_BEG)) && (hcnt < HW'(H_ACT_END));
    v_act     = (vcnt >= VW'(V_ACT_BEG)) && (vcnt < VW'(V_ACT_END));
    col       = CW'(hcnt) - CW'(H_ACT_BEG);
    row       = CW'(vcnt) - CW'(V_ACT_BEG);
    col_end   = CW'(win_q.sx) + CW'(win_q.w);
    row_end   = CW'(win_q.sy) + CW'(win_q.h);
    h_in      = (col >= CW'(win_q.sx)) && (col < col_end);
    v_in      = (row >= CW'(win_q.sy)) && (row < row_end);
    in_active = h_act && v_act;
    in_window = in_active && h_in && v_in;
  end

  // R9
  empty_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_q.w == '0) || (win_q.h == '0)) |-> !in_window);

  // R6
  win_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> in_active);

endmodule

// File: rtl/vtg_frame_raster.sv
module vtg_frame_raster
  import vtg_pkg::*;
#(
  parameter  int unsigned H_ACT     = 1920,
  parameter  int unsigned H_FP      = 88,
  parameter  int unsigned H_SYNC    = 44,
  parameter  int unsigned H_BP      = 148,
  parameter  int unsigned V_ACT     = 1080,
  parameter  int unsigned V_FP      = 4,
  parameter  int unsigned V_SYNC    = 5,
  parameter  int unsigned V_BP      = 36,
  parameter  int unsigned RGB_W     = 24,
  localparam int unsigned H_TOTAL   = H_SYNC + H_BP + H_ACT + H_FP,
  localparam int unsigned V_TOTAL   = V_SYNC + V_BP + V_ACT + V_FP,
  localparam int unsigned H_ACT_BEG = H_SYNC + H_BP,
  localparam int unsigned V_ACT_BEG = V_SYNC + V_BP,
  localparam int unsigned HW        = $clog2(H_TOTAL),
  localparam int unsigned VW        = $clog2(V_TOTAL)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [VTG_SIZE_W-1:0] i_start_x,
  input  logic [VTG_SIZE_W-1:0] i_start_y,
  input  logic [VTG_SIZE_W-1:0] i_width,
  input  logic [VTG_SIZE_W-1:0] i_height,
  input  logic [RGB_W-1:0]      i_rgb,
  output logic                  o_hs,
  output logic                  o_vs,
  output logic                  o_de,
  output logic [RGB_W-1:0]      o_rgb,
  output logic                  o_req
);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          frame_start;
  logic          line_sync;
  logic          frame_sync;
  logic          in_active;
  logic          in_window;
  vtg_flags_t    s1_q;
  vtg_flags_t    s1_nxt;
  vtg_flags_t    s2_q;

  vtg_scan_counter #(
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL),
    .H_SYNC  (H_SYNC),
    .V_SYNC  (V_SYNC)
  ) i_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .hcnt        (hcnt),
    .vcnt        (vcnt),
    .frame_start (frame_start),
    .line_sync   (line_sync),
    .frame_sync  (frame_sync)
  );

  vtg_window_gate #(
    .H_TOTAL   (H_TOTAL),
    .V_TOTAL   (V_TOTAL),
    .H_ACT_BEG (H_ACT_BEG),
    .V_ACT_BEG (V_ACT_BEG),
    .H_ACT     (H_ACT),
    .V_ACT     (V_ACT)
  ) i_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .hcnt        (hcnt),
    .vcnt        (vcnt),
    .frame_start (frame_start),
    .start_x     (i_start_x),
    .start_y     (i_start_y),
    .width       (i_width),
    .height      (i_height),
    .in_active   (in_active),
    .in_window   (in_window)
  );

  // Stage 1 carries the request; stage 2 aligns flags with returned data.
  always_comb begin
    s1_nxt.hs  = line_sync;
    s1_nxt.vs  = frame_sync;
    s1_nxt.de  = in_active;
    s1_nxt.win = in_window;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_nxt;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    o_req = s1_q.win;
    o_hs  = s2_q.hs;
    o_vs  = s2_q.vs;
    o_de  = s2_q.de;
    o_rgb = s2_q.win ? i_rgb : '0;
  end

  // R4
  de_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_de |-> (!o_hs && !o_vs));

  // R5
  req_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_req |=> o_de);

  // R7
  rgb_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !o_de |-> (o_rgb == '0));

endmodule

// File: tb/test_vtg_frame_raster.sv
module test_vtg_frame_raster;

  localparam int HA = 16, HFP = 3, HS = 2, HBP = 3;
  localparam int VA = 8,  VFP = 1, VS = 1, VBP = 2;
  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int FR = HT * VT;
  localparam int HAB = HS + HBP;
  localparam int VAB = VS + VBP;
  localparam int NFR = 7;
  localparam int MID = 4 * FR + 100;
  localparam logic [23:0] BASE = 24'hA50000;

  logic        clk;
  logic        rst_n;
  logic [10:0] i_start_x, i_start_y, i_width, i_height;
  logic [23:0] i_rgb;
  logic        o_hs, o_vs, o_de, o_req;
  logic [23:0] o_rgb;

  int checks;
  int errors;
  int wsx[NFR], wsy[NFR], ww[NFR], wh[NFR];
  int shown;

  vtg_frame_raster #(
    .H_ACT(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_ACT(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP)
  ) i_vtg_frame_raster (
    .clk(clk), .rst_n(rst_n),
    .i_start_x(i_start_x), .i_start_y(i_start_y),
    .i_width(i_width), .i_height(i_height),
    .i_rgb(i_rgb),
    .o_hs(o_hs), .o_vs(o_vs), .o_de(o_de), .o_rgb(o_rgb), .o_req(o_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Frame-buffer model: synchronous read, one clock of latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) i_rgb <= BASE;
    else if (o_req) i_rgb <= i_rgb + 24'd1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_win(input int sx, input int sy, input int w, input int h);
    i_start_x = 11'(sx); i_start_y = 11'(sy);
    i_width   = 11'(w);  i_height  = 11'(h);
  endtask

  function automatic bit in_win(input int p);
    int f = p / FR;
    int x = (p % HT) - HAB;
    int y = ((p / HT) % VT) - VAB;
    return (x >= 0) && (x < HA) && (y >= 0) && (y < VA) &&
           (x >= wsx[f]) && (x < wsx[f] + ww[f]) &&
           (y >= wsy[f]) && (y < wsy[f] + wh[f]);
  endfunction

  task automatic sched(input int f);
    case (f)
      0: set_win(0, 0, 16, 8);   // full window
      1: set_win(2, 1, 5, 3);    // inner rectangle
      2: set_win(12, 6, 10, 10); // clipped at the right and bottom edges
      3: set_win(3, 3, 0, 4);    // zero width
      4: set_win(0, 0, 16, 8);   // changed mid-frame below
      5: set_win(1, 1, 2, 2);
      default: set_win(5, 2, 4, 0); // zero height
    endcase
    wsx[f] = int'(i_start_x); wsy[f] = int'(i_start_y);
    ww[f]  = int'(i_width);   wh[f]  = int'(i_height);
  endtask

  task automatic check_cycle(input int k);
    int pr = k - 1;
    int pd = k - 2;
    bit er = in_win(pr);
    bit ehs, evs, ede, ewin;
    int h, v;
    logic [23:0] erg;
    // R5 R6 R8 R9: request one clock ahead of each windowed pixel
    chk(o_req == er, "R5/R6/R8/R9 req", o_req, er);
    if (pd < 0) begin
      ehs = 0; evs = 0; ede = 0; ewin = 0;
    end else begin
      h = pd % HT; v = (pd / HT) % VT;
      ehs  = h < HS;
      evs  = v < VS;
      ede  = (h >= HAB) && (h < HAB + HA) && (v >= VAB) && (v < VAB + VA);
      ewin = in_win(pd);
    end
    if (ewin) begin
      shown++;
      erg = BASE + 24'(shown);
    end else begin
      erg = '0;
    end
    // R1 R2: start position and line sync
    chk(o_hs == ehs, "R2 hsync", o_hs, ehs);
    // R3
    chk(o_vs == evs, "R3 vsync", o_vs, evs);
    // R4
    chk(o_de == ede, "R4 de", o_de, ede);
    // R7
    chk(o_rgb == erg, "R7 rgb", o_rgb, erg);
  endtask

  initial begin
    checks = 0; errors = 0; shown = 0;
    rst_n = 1'b0;
    sched(0);
    repeat (3) begin
      @(negedge clk);
      // R1
      chk({o_hs, o_vs, o_de, o_req} == 4'b0, "R1 reset flags",
          {o_hs, o_vs, o_de, o_req}, 0);
      chk(o_rgb == '0, "R1 reset rgb", o_rgb, 0);
    end
    rst_n = 1'b1;
    for (int k = 1; k <= NFR * FR; k++) begin
      @(negedge clk);
      check_cycle(k);
      if ((k % FR) == 0 && (k / FR) < NFR) sched(k / FR);
      if (k == MID) set_win(1, 1, 2, 2); // R8: ignored until frame 5
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule